// File: doc/BRIEF.md
# ATAPI Drive-Side Transfer Mode and Pin Control Registers

This block sits on the drive controller's byte-wide microcontroller bus. It holds the two registers that firmware uses to set up host transfers and to drive the two shared drive-status pins of the ATA cable. The first register selects the transfer protocol (programmed I/O, multi-word DMA or Ultra DMA) and the direction. It is written at one address, and a status view of it is read back at the same address. That status view also reports whether a processor-to-RAM copy is still running.

The second register is read/write. Two of its bits enable the active-low diagnostic-pass and drive-active pins. Host-side events clear these enables in hardware, so the pins return to high impedance without firmware taking part. The events are the execute-drive-diagnostics command (opcode 90h written to the command register), a soft reset, and a host reset. A host reset clears only the diagnostic enable. Each pin leaves the block as an output-enable and a drive-low signal, and the pad cell outside turns them into an open-drain-style line. Reads are registered and return data one clock after the read strobe.

Top module: `hif_ctl_regs`

## Requirements
- R1: When chip reset ends, register 20h holds 26h and the mode register holds 0h. The diagnostic pin is therefore high-impedance and the drive-active pin is driven low.
- R2: A write to address 1Fh stores write-data bits 3..0 and ignores bits 7..4. The stored value appears on `mode_o` one clock later: bit 0 is Ultra DMA enable, bit 1 is data-in, bit 2 is PIO select and bit 3 is multi-word DMA.
- R3: `xfer_kind_o` decodes the stored mode. Ch and Eh give 0 (PIO), 8h and Ah give 1 (multi-word DMA), 9h and Bh give 2 (Ultra DMA), and every other value gives 3 (invalid). `dir_in_o` equals mode bit 1.
- R4: A read strobe at address 1Fh returns, one clock later, the mode in bits 3..0, zeros in bits 6..4, and in bit 7 the value of `ram_xfer_busy_i` in the strobe cycle. A read of an unmapped address returns 00h.
- R5: A write to address 20h stores bits 6..0. Bit 7 always reads as 0, and writing it has no effect.
- R6: While bit 6 of register 20h is 1, `diag_oe_o` and `diag_lo_o` are both 1 (pin driven low). While the bit is 0, both are 0 (high-impedance).
- R7: While bit 5 of register 20h is 1, `act_oe_o` and `act_lo_o` are both 1. While the bit is 0, both are 0.
- R8: A command-register write (`cmd_wr_i` high) of 90h clears bits 6 and 5 of register 20h on the next clock. Other command values, and 90h without `cmd_wr_i`, change nothing. Bits 4..0 are never touched by these events.
- R9: A soft-reset strobe clears bits 6 and 5 of register 20h on the next clock.
- R10: A host-reset strobe clears bit 6 of register 20h and leaves bit 5 unchanged.
- R11: When a write to 20h and a clear event fall in the same cycle, the cleared bits end at 0. The other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| host_rst_i | input | 1 | Host reset strobe, one cycle |
| srst_i | input | 1 | ATA soft reset strobe, one cycle |
| cmd_wr_i | input | 1 | Host command register write strobe |
| cmd_data_i | input | 8 | Command byte written by the host |
| bus_wr_i | input | 1 | Microcontroller register write strobe |
| bus_rd_i | input | 1 | Microcontroller register read strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| ram_xfer_busy_i | input | 1 | Processor-to-RAM copy still in progress |
| mode_o | output | 4 | Stored transfer-mode bits |
| xfer_kind_o | output | 2 | Decoded protocol: 0 PIO, 1 MDMA, 2 UDMA, 3 invalid |
| dir_in_o | output | 1 | Data-in direction selected |
| diag_oe_o | output | 1 | Diagnostic pin output enable |
| diag_lo_o | output | 1 | Diagnostic pin drive-low |
| act_oe_o | output | 1 | Drive-active pin output enable |
| act_lo_o | output | 1 | Drive-active pin drive-low |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. That covers a register write reaching `mode_o` or the pin outputs, an event clearing an enable, and read data showing on `bus_rdata_o`. The driver applies each stimulus just after a falling edge and records the expected item with the current cycle number. The monitor compares that item at the next falling edge, which is half a period after the capturing rising edge. No check reads state before the edge that updates it. Read strobes are never combined with writes, so the expected read value is the register content before the cycle's update.

// File: rtl/hif_pkg.sv
package hif_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int MODE_W   = 4;
    localparam int CTRL_W   = 7;
    localparam int NUM_PINS = 2;

    localparam logic [ADDR_W-1:0] MODE_ADDR = 8'h1F;
    localparam logic [ADDR_W-1:0] PIN_ADDR  = 8'h20;
    localparam logic [DATA_W-1:0] DIAG_OPC  = 8'h90;
    localparam logic [CTRL_W-1:0] CTRL_RST  = 7'h26;
    localparam logic [MODE_W-1:0] MODE_RST  = 4'h0;

    localparam int DIAG_BIT = 6;
    localparam int ACT_BIT  = 5;

    // pin index in the pin driver vector
    localparam int PIN_DIAG = 0;
    localparam int PIN_ACT  = 1;

    typedef enum logic [1:0] {
        XK_PIO   = 2'd0,
        XK_MWDMA = 2'd1,
        XK_ULTRA = 2'd2,
        XK_BAD   = 2'd3
    } xfer_kind_e;

    // bit 3 .. bit 0 of the mode register
    typedef struct packed {
        logic mword;
        logic pio;
        logic dir_in;
        logic ultra;
    } mode_t;

    typedef struct packed {
        logic diag;
        logic act;
    } clr_t;

    function automatic xfer_kind_e decode_kind(input mode_t m);
        xfer_kind_e k;
        case ({m.mword, m.pio, m.ultra})
            3'b110:  k = XK_PIO;
            3'b100:  k = XK_MWDMA;
            3'b101:  k = XK_ULTRA;
            default: k = XK_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/hif_event_dec.sv
module hif_event_dec
    import hif_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter logic [DW-1:0] OPC = DIAG_OPC
) (
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_data,
    input  logic          srst,
    input  logic          host_rst,
    output clr_t          clr
);
    logic diag_cmd;

    always_comb begin
        diag_cmd = cmd_wr && (cmd_data == OPC);
        clr.act  = diag_cmd || srst;
        clr.diag = diag_cmd || srst || host_rst;
    end

endmodule

// File: rtl/hif_mode_reg.sv
module hif_mode_reg
    import hif_pkg::*;
#(
    parameter int MW = MODE_W,
    parameter logic [MW-1:0] RST_VAL = MODE_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [MW-1:0] wdata,
    output mode_t         mode,
    output xfer_kind_e    kind
);
    logic [MW-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= RST_VAL;
        else if (wr)
            mode_q <= wdata;
    end

    always_comb begin
        mode = mode_t'(mode_q);
        kind = decode_kind(mode);
    end

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr |=> (mode_q == $past(wdata))) else $error("mode write lost"); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(mode_q)) else $error("mode changed without write"); // R2

endmodule

// File: rtl/hif_pin_ctrl.sv
module hif_pin_ctrl
    import hif_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter logic [CW-1:0] RST_VAL = CTRL_RST,
    parameter int DBIT = DIAG_BIT,
    parameter int ABIT = ACT_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  clr_t          clr,
    output logic [CW-1:0] ctrl
);
    logic [CW-1:0] ctrl_q;
    logic [CW-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr)
            ctrl_d = wdata;
        // hardware clears take priority over a same-cycle write
        if (clr.diag)
            ctrl_d[DBIT] = 1'b0;
        if (clr.act)
            ctrl_d[ABIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= RST_VAL;
        else
            ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    AST_DIAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr.diag |=> !ctrl_q[DBIT]) else $error("diag enable survived clear"); // R8

    AST_ACT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr.act |=> !ctrl_q[ABIT]) else $error("active enable survived clear"); // R9

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr && clr.diag && clr.act) |=> (ctrl_q[DBIT] == 1'b0 && ctrl_q[ABIT] == 1'b0))
        else $error("write beat clear"); // R11

    AST_HOST_KEEPS_ACT: assert property (@(posedge clk) disable iff (rst)
        (clr.diag && !clr.act && !wr) |=> $stable(ctrl_q[ABIT]))
        else $error("active enable moved on diag-only clear"); // R10

    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctrl_q[ABIT-1:0])) else $error("low bits changed"); // R8

endmodule

// File: rtl/hif_pin_drv.sv
module hif_pin_drv
    import hif_pkg::*;
#(
    parameter int NP = NUM_PINS
) (
    input  logic [NP-1:0] en,
    output logic [NP-1:0] oe,
    output logic [NP-1:0] lo
);
    // active-low, open-drain-style: enabled pins are driven to 0
    for (genvar i = 0; i < NP; i++) begin : g_pin
        assign oe[i] = en[i];
        assign lo[i] = en[i];
    end

endmodule

// File: rtl/hif_ctl_regs.sv
module hif_ctl_regs
    import hif_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int MW = MODE_W,
    parameter int CW = CTRL_W,
    parameter logic [AW-1:0] MODE_A = MODE_ADDR,
    parameter logic [AW-1:0] PIN_A  = PIN_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rst_i,
    input  logic          srst_i,
    input  logic          cmd_wr_i,
    input  logic [DW-1:0] cmd_data_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic          ram_xfer_busy_i,
    output logic [MW-1:0] mode_o,
    output logic [1:0]    xfer_kind_o,
    output logic          dir_in_o,
    output logic          diag_oe_o,
    output logic          diag_lo_o,
    output logic          act_oe_o,
    output logic          act_lo_o
);
    localparam int NP = NUM_PINS;

    logic          sel_mode;
    logic          sel_pin;
    clr_t          clr;
    mode_t         mode;
    xfer_kind_e    kind;
    logic [CW-1:0] ctrl;
    logic [NP-1:0] pin_en;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_lo;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;
    logic          unused_wdata_hi;

    assign sel_mode = (bus_addr_i == MODE_A);
    assign sel_pin  = (bus_addr_i == PIN_A);

    // write-data bits beyond the control register width are reserved
    assign unused_wdata_hi = &{1'b0, bus_wdata_i[DW-1:CW]};

    hif_event_dec #(.DW(DW), .OPC(DIAG_OPC)) u_evt (
        .cmd_wr   (cmd_wr_i),
        .cmd_data (cmd_data_i),
        .srst     (srst_i),
        .host_rst (host_rst_i),
        .clr      (clr)
    );

    hif_mode_reg #(.MW(MW), .RST_VAL(MODE_RST)) u_mode (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr_i && sel_mode),
        .wdata (bus_wdata_i[MW-1:0]),
        .mode  (mode),
        .kind  (kind)
    );

    hif_pin_ctrl #(.CW(CW), .RST_VAL(CTRL_RST), .DBIT(DIAG_BIT), .ABIT(ACT_BIT)) u_pins (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr_i && sel_pin),
        .wdata (bus_wdata_i[CW-1:0]),
        .clr   (clr),
        .ctrl  (ctrl)
    );

    always_comb begin
        pin_en           = '0;
        pin_en[PIN_DIAG] = ctrl[DIAG_BIT];
        pin_en[PIN_ACT]  = ctrl[ACT_BIT];
    end

    hif_pin_drv #(.NP(NP)) u_drv (
        .en (pin_en),
        .oe (pin_oe),
        .lo (pin_lo)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_mode) begin
            rd_mux[MW-1:0] = mode;
            rd_mux[DW-1]   = ram_xfer_busy_i;
        end else if (sel_pin) begin
            rd_mux[CW-1:0] = ctrl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_rd_i)
            rdata_q <= rd_mux;
    end

    assign bus_rdata_o = rdata_q;
    assign mode_o      = mode;
    assign xfer_kind_o = kind;
    assign dir_in_o    = mode.dir_in;
    assign diag_oe_o   = pin_oe[PIN_DIAG];
    assign diag_lo_o   = pin_lo[PIN_DIAG];
    assign act_oe_o    = pin_oe[PIN_ACT];
    assign act_lo_o    = pin_lo[PIN_ACT];

    AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && sel_mode) |=> (bus_rdata_o[DW-2:MW] == '0))
        else $error("reserved status bits set"); // R4

    AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && sel_mode) |=> (bus_rdata_o[DW-1] == $past(ram_xfer_busy_i)))
        else $error("busy flag wrong"); // R4

    AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && sel_pin) |=> !bus_rdata_o[DW-1]) else $error("bit 7 read as 1"); // R5

    AST_DIAG_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        diag_oe_o |-> (ctrl[DIAG_BIT] && diag_lo_o)) else $error("diag pin without enable"); // R6

    AST_ACT_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        act_oe_o |-> (ctrl[ACT_BIT] && act_lo_o)) else $error("active pin without enable"); // R7

endmodule

// File: tb/tb_hif_ctl_regs.sv
`timescale 1ns/1ps
module tb_hif_ctl_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rst_i = 1'b0;
    logic       srst_i = 1'b0;
    logic       cmd_wr_i = 1'b0;
    logic [7:0] cmd_data_i = 8'h00;
    logic       bus_wr_i = 1'b0;
    logic       bus_rd_i = 1'b0;
    logic [7:0] bus_addr_i = 8'h00;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic       ram_xfer_busy_i = 1'b0;
    logic [3:0] mode_o;
    logic [1:0] xfer_kind_o;
    logic       dir_in_o;
    logic       diag_oe_o, diag_lo_o, act_oe_o, act_lo_o;

    always #10 clk = ~clk;   // 50 MHz

    hif_ctl_regs dut (
        .clk (clk), .rst (rst), .host_rst_i (host_rst_i), .srst_i (srst_i),
        .cmd_wr_i (cmd_wr_i), .cmd_data_i (cmd_data_i),
        .bus_wr_i (bus_wr_i), .bus_rd_i (bus_rd_i), .bus_addr_i (bus_addr_i),
        .bus_wdata_i (bus_wdata_i), .bus_rdata_o (bus_rdata_o),
        .ram_xfer_busy_i (ram_xfer_busy_i), .mode_o (mode_o),
        .xfer_kind_o (xfer_kind_o), .dir_in_o (dir_in_o),
        .diag_oe_o (diag_oe_o), .diag_lo_o (diag_lo_o),
        .act_oe_o (act_oe_o), .act_lo_o (act_lo_o)
    );

    // observed vector: mode | rdata | diag_oe diag_lo act_oe act_lo | kind | dir | 0
    logic [19:0] obs;
    assign obs = {mode_o, bus_rdata_o, diag_oe_o, diag_lo_o, act_oe_o, act_lo_o,
                  xfer_kind_o, dir_in_o, 1'b0};

    localparam logic [19:0] STATE_MASK = 20'hF00FF;
    localparam logic [19:0] RD_MASK    = 20'h0FF00;

    typedef struct {
        int          due;
        logic [19:0] mask;
        logic [19:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    item_t cur;
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    // bench model, kept from the requirements
    logic [3:0] m_mode = 4'h0;
    logic [7:0] m_ctrl = 8'h26;

    function automatic logic [1:0] ref_kind(input logic [3:0] m);
        case (m)
            4'hC, 4'hE: return 2'd0;
            4'h8, 4'hA: return 2'd1;
            4'h9, 4'hB: return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

    function automatic logic [19:0] model_vec(input logic [7:0] rd);
        return {m_mode, rd, m_ctrl[6], m_ctrl[6], m_ctrl[5], m_ctrl[5],
                ref_kind(m_mode), m_mode[1], 1'b0};
    endfunction

    // monitor: compare items due at this falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            cur = sb.pop_front();
            checks++;
            if (((obs ^ cur.exp) & cur.mask) != 20'h0) begin
                errors++;
                $display("FAIL %s: actual %05h expected %05h (cycle %0d)",
                         cur.req, obs & cur.mask, cur.exp & cur.mask, cyc);
            end
        end
        cyc = cyc + 1;
    end

    task automatic push(input logic [19:0] m, input logic [19:0] e, input string r);
        item_t it;
        it.due = cyc; it.mask = m; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    // one stimulus cycle; results due at the next falling edge
    task automatic drive(input logic wr, input logic [7:0] a, input logic [7:0] d,
                         input logic rd, input logic cw, input logic [7:0] cd,
                         input logic sr, input logic hr, input logic bz,
                         input string r);
        logic [7:0] rexp;
        @(negedge clk); #1;
        bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d; bus_rd_i = rd;
        cmd_wr_i = cw; cmd_data_i = cd; srst_i = sr; host_rst_i = hr;
        ram_xfer_busy_i = bz;
        rexp = 8'h00;
        if (a == 8'h1F)      rexp = {bz, 3'b000, m_mode};
        else if (a == 8'h20) rexp = {1'b0, m_ctrl[6:0]};
        if (wr && a == 8'h1F) m_mode = d[3:0];
        if (wr && a == 8'h20) m_ctrl = {1'b0, d[6:0]};
        if ((cw && cd == 8'h90) || sr) begin m_ctrl[6] = 1'b0; m_ctrl[5] = 1'b0; end
        if (hr) m_ctrl[6] = 1'b0;
        if (rd) push(RD_MASK, model_vec(rexp), r);
        else    push(STATE_MASK, model_vec(8'h00), r);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d, input string r);
        drive(1'b1, a, d, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, r);
    endtask

    task automatic rreg(input logic [7:0] a, input logic bz, input string r);
        drive(1'b0, a, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, bz, r);
    endtask

    task automatic idle(input string r);
        drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, r);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [3:0] encs [9] = '{4'hC, 4'hE, 4'h8, 4'hA, 4'h9, 4'hB, 4'h0, 4'h5, 4'hF};

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1: reset state of pins and mode
        idle("R1 reset state");
        rreg(8'h20, 1'b0, "R1 control reads 26h");
        rreg(8'h1F, 1'b0, "R1 mode reads 0");

        // R2, R3, R4: every mode encoding with junk in the upper nibble
        for (int i = 0; i < 9; i++) begin
            wreg(8'h1F, {4'hA, encs[i]}, "R2 R3 mode write and decode");
            rreg(8'h1F, 1'b1, "R4 status read busy high");
            rreg(8'h1F, 1'b0, "R4 status read busy low");
        end
        rreg(8'h00, 1'b1, "R4 unmapped reads 0");
        rreg(8'h55, 1'b0, "R4 unmapped reads 0");

        // R5, R6, R7
        wreg(8'h20, 8'hFF, "R6 R7 both pins driven");
        rreg(8'h20, 1'b0, "R5 bit 7 reads 0");
        wreg(8'h20, 8'h00, "R6 R7 both pins released");
        rreg(8'h20, 1'b0, "R5 cleared readback");
        wreg(8'h20, 8'h40, "R6 diag only");
        wreg(8'h20, 8'h20, "R7 active only");
        wreg(8'h20, 8'h95, "R5 bit 7 write ignored");
        rreg(8'h20, 1'b0, "R5 readback 15h");

        // R8: diagnostics opcode
        wreg(8'h20, 8'h7F, "R8 setup");
        drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h91, 1'b0, 1'b0, 1'b0, "R8 other opcode no clear");
        drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h90, 1'b0, 1'b0, 1'b0, "R8 opcode without strobe");
        drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h90, 1'b0, 1'b0, 1'b0, "R8 opcode 90h clears");
        rreg(8'h20, 1'b0, "R8 readback 1Fh");

        // R9: soft reset
        wreg(8'h20, 8'h7F, "R9 setup");
        drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R9 soft reset clears");
        rreg(8'h20, 1'b0, "R9 readback");

        // R10: host reset keeps the active enable
        wreg(8'h20, 8'h7F, "R10 setup");
        drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R10 host reset diag only");
        rreg(8'h20, 1'b0, "R10 readback 3Fh");
        wreg(8'h20, 8'h00, "R10 setup low");
        drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R10 host reset on clear reg");

        // R11: same-cycle write and clear
        drive(1'b1, 8'h20, 8'h7F, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R11 write vs soft reset");
        rreg(8'h20, 1'b0, "R11 readback");
        drive(1'b1, 8'h20, 8'h6A, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R11 write vs host reset");
        rreg(8'h20, 1'b0, "R11 readback 2Ah");
        drive(1'b1, 8'h20, 8'h63, 1'b0, 1'b1, 8'h90, 1'b0, 1'b0, 1'b0, "R11 write vs opcode");
        rreg(8'h20, 1'b0, "R11 readback 03h");

        // R1: chip reset mid-run reloads defaults
        @(negedge clk); #1 rst = 1'b1;
        @(negedge clk); #1 rst = 1'b0;
        m_mode = 4'h0; m_ctrl = 8'h26;
        idle("R1 reset again");
        rreg(8'h20, 1'b0, "R1 control reads 26h again");

        repeat (3) idle("drain");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule